// File: doc/BRIEF.md
# Interrupt Enable and Steering Unit

This block merges four level-sensitive interrupt requests into the two interrupt lines of a processor core: a normal line (IRQ) and a fast line (FIQ). Two of the requests come from external pins and have fixed destinations. The external fast request always drives FIQ, and the external normal request always drives IRQ. The other two come from on-chip units, a performance monitor and a bus controller. Each of these two can be sent to either line by its own steering bit.

Software reaches the block through three 32-bit registers, selected by a 2-bit code: 0 is control, 1 is source and 2 is steer. Code 3 selects nothing and reads as zero. Control holds one enable per request. Steer holds one routing bit per on-chip request. Source is a read-only view of the requests that are both asserted and enabled. The read port is combinational. A write lands on the clock edge at which it is presented.

The two interrupt outputs are registered, so they follow the gated requests one edge later. The asynchronous active-low reset is asserted at once and released through a two-stage synchronizer.

Top module: `irqs_top`

## Requirements
- R1: After reset, control and steer read 0, the source register reads 0 whatever the requests are, and irq_o and fiq_o are 0.
- R2: Control bits 0 (external fast request enable), 1 (external normal request enable), 2 (performance-monitor enable) and 3 (bus-controller enable) are writable and read back. Control bits 31:4 read 0 whatever is written.
- R3: Steer bits 0 (performance-monitor route) and 1 (bus-controller route) are writable and read back. Steer bits 31:2 read 0.
- R4: Source bit 31 is the external fast request, bit 30 the external normal request, bit 28 the performance-monitor request and bit 29 the bus-controller request. Each bit is 1 only while its request is high and its enable bit is set. All other source bits read 0. The read path is combinational.
- R5: The enabled external fast request drives only fiq_o, and the enabled external normal request drives only irq_o, whatever the steer value.
- R6: The enabled performance-monitor request drives irq_o when steer bit 0 is 0 and fiq_o when it is 1.
- R7: The enabled bus-controller request drives irq_o when steer bit 1 is 0 and fiq_o when it is 1.
- R8: irq_o and fiq_o each equal the OR of the enabled requests routed to that line, registered once. A request change appears on the outputs after the next rising clock edge and not before.
- R9: A write with select 1 (source) or select 3 changes neither control nor steer. A read with select 3 returns 0.
- R10: A request whose enable bit is clear affects neither output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 control, 1 source, 2 steer, 3 none |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 32 | Combinational read data |
| ext_fiq_req | input | 1 | External fast interrupt request, active high, level |
| ext_irq_req | input | 1 | External normal interrupt request, active high, level |
| pmu_req | input | 1 | Performance-monitor interrupt request |
| bus_req | input | 1 | Bus-controller interrupt request |
| irq_o | output | 1 | Normal interrupt line to the core (registered) |
| fiq_o | output | 1 | Fast interrupt line to the core (registered) |

## Verification
The source register is due in the same cycle that a request or enable is applied. irq_o and fiq_o are due after exactly one rising edge. A register write is due on the edge at which it is presented. The driver changes requests only at falling edges and pushes the expected source word and output levels into a queue. The monitor pops each item a quarter period after the next rising edge, while the requests are still held, so both the combinational read and the one-edge output latency are checked against the same item. A separate check samples the outputs just before and just after that edge, to show that the latency is exactly one edge.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned N_INT  = 2;            // steerable on-chip requests
  localparam int unsigned CTL_W  = 2 + N_INT;    // enables kept in control
  localparam int unsigned STR_W  = N_INT;        // routing bits kept in steer

  // enable bit positions in the control word
  localparam int unsigned CTL_EXT_FIQ  = 0;
  localparam int unsigned CTL_EXT_IRQ  = 1;
  localparam int unsigned CTL_INT_BASE = 2;      // + index: 0 perf mon, 1 bus ctl

  // status bit positions in the source word
  localparam int unsigned SRC_INT_BASE = 28;
  localparam int unsigned SRC_EXT_IRQ  = 30;
  localparam int unsigned SRC_EXT_FIQ  = 31;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTL  = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_STR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             ext_fiq;
    logic             ext_irq;
    logic [N_INT-1:0] intl;
  } req_t;
endpackage

// File: rtl/irqs_rst_sync.sv
module irqs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/irqs_cfg_regs.sv
module irqs_cfg_regs
  import irqs_pkg::*;
#(
  parameter int unsigned DW  = WORD_W,
  parameter int unsigned CW  = CTL_W,
  parameter int unsigned SW  = STR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic [CW-1:0]    ctl_q,
  output logic [SW-1:0]    str_q
);
  logic          ctl_ce, str_ce;
  logic [CW-1:0] ctl_d;
  logic [SW-1:0] str_d;

  // next state: only the implemented low bits are taken
  always_comb begin
    ctl_ce = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);
    str_ce = wr_en && (reg_sel_e'(wr_sel) == SEL_STR);
    ctl_d  = wr_data[CW-1:0];
    str_d  = wr_data[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      str_q <= '0;
    end else begin
      if (ctl_ce) ctl_q <= ctl_d;
      if (str_ce) str_q <= str_d;
    end
  end
endmodule

// File: rtl/irqs_route.sv
module irqs_route
  import irqs_pkg::*;
(
  input  logic [CTL_W-1:0]  ctl,
  input  logic [STR_W-1:0]  str,
  input  req_t              req,
  output logic [WORD_W-1:0] src_word,
  output logic              irq_nxt,
  output logic              fiq_nxt
);
  logic             ext_fiq_live, ext_irq_live;
  logic [N_INT-1:0] int_live, to_irq, to_fiq;

  assign ext_fiq_live = req.ext_fiq & ctl[CTL_EXT_FIQ];
  assign ext_irq_live = req.ext_irq & ctl[CTL_EXT_IRQ];

  // one gate-and-steer slice per on-chip request
  for (genvar i = 0; i < N_INT; i++) begin : g_int
    assign int_live[i] = req.intl[i] & ctl[CTL_INT_BASE+i];
    assign to_fiq[i]   = int_live[i] &  str[i];
    assign to_irq[i]   = int_live[i] & ~str[i];
  end

  always_comb begin
    src_word = '0;
    src_word[SRC_EXT_FIQ] = ext_fiq_live;
    src_word[SRC_EXT_IRQ] = ext_irq_live;
    for (int i = 0; i < N_INT; i++) begin
      src_word[SRC_INT_BASE+i] = int_live[i];
    end
    irq_nxt = ext_irq_live | (|to_irq);
    fiq_nxt = ext_fiq_live | (|to_fiq);
  end
endmodule

// File: rtl/irqs_out_reg.sv
module irqs_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_d,
  input  logic fiq_d,
  output logic irq_q,
  output logic fiq_q
);
  logic out_ce;
  assign out_ce = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else if (out_ce) begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end
endmodule

// File: rtl/irqs_top.sv
module irqs_top
  import irqs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic              ext_fiq_req,
  input  logic              ext_irq_req,
  input  logic              pmu_req,
  input  logic              bus_req,
  output logic              irq_o,
  output logic              fiq_o
);
  logic              rst_sync_n;
  logic [CTL_W-1:0]  ctl_q;
  logic [STR_W-1:0]  str_q;
  logic [WORD_W-1:0] src_word;
  logic              irq_nxt, fiq_nxt;
  req_t              req;

  assign req.ext_fiq = ext_fiq_req;
  assign req.ext_irq = ext_irq_req;
  assign req.intl    = {bus_req, pmu_req};

  irqs_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  irqs_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ctl_q   (ctl_q),
    .str_q   (str_q)
  );

  irqs_route u_route (
    .ctl      (ctl_q),
    .str      (str_q),
    .req      (req),
    .src_word (src_word),
    .irq_nxt  (irq_nxt),
    .fiq_nxt  (fiq_nxt)
  );

  irqs_out_reg u_out (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .irq_d (irq_nxt),
    .fiq_d (fiq_nxt),
    .irq_q (irq_o),
    .fiq_q (fiq_o)
  );

  always_comb begin
    rd_data = '0;
    unique case (reg_sel_e'(rd_sel))
      SEL_CTL:  rd_data[CTL_W-1:0] = ctl_q;
      SEL_STR:  rd_data[STR_W-1:0] = str_q;
      SEL_SRC:  rd_data = src_word;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk
  import irqs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [CTL_W-1:0] ctl_q,
  input logic [STR_W-1:0] str_q,
  input logic             ext_fiq_req,
  input logic             ext_irq_req,
  input logic             pmu_req,
  input logic             bus_req,
  input logic             irq_o,
  input logic             fiq_o
);
  // R5
  ext_fiq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_fiq_req && ctl_q[CTL_EXT_FIQ]) |=> fiq_o);
  // R5
  ext_irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq_req && ctl_q[CTL_EXT_IRQ]) |=> irq_o);
  // R6
  pmu_to_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pmu_req && ctl_q[CTL_INT_BASE] && !str_q[0]) |=> irq_o);
  // R6
  pmu_to_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pmu_req && ctl_q[CTL_INT_BASE] && str_q[0]) |=> fiq_o);
  // R7
  bus_to_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && ctl_q[CTL_INT_BASE+1] && !str_q[1]) |=> irq_o);
  // R7
  bus_to_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && ctl_q[CTL_INT_BASE+1] && str_q[1]) |=> fiq_o);
  // R10
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == '0) |=> (!irq_o && !fiq_o));
  // R9
  src_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == SEL_SRC || wr_sel == SEL_NONE)) |=>
      ($stable(ctl_q) && $stable(str_q)));
endmodule

bind irqs_top irqs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .ctl_q       (ctl_q),
  .str_q       (str_q),
  .ext_fiq_req (ext_fiq_req),
  .ext_irq_req (ext_irq_req),
  .pmu_req     (pmu_req),
  .bus_req     (bus_req),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o)
);

// File: tb/sim_irqs_top.sv
module sim_irqs_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        ext_fiq_req, ext_irq_req, pmu_req, bus_req;
  logic        irq_o, fiq_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [3:0] ctl_m;
  logic [1:0] str_m;

  typedef struct packed {
    logic [31:0] src;
    logic        irq;
    logic        fiq;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  irqs_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .ext_fiq_req(ext_fiq_req), .ext_irq_req(ext_irq_req),
    .pmu_req(pmu_req), .bus_req(bus_req), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic f, input logic i,
                                 input logic p, input logic b);
    exp_t e;
    logic fl, il, pl, bl;
    fl = f & ctl_m[0]; il = i & ctl_m[1];
    pl = p & ctl_m[2]; bl = b & ctl_m[3];
    e.src = '0;
    e.src[31] = fl; e.src[30] = il; e.src[28] = pl; e.src[29] = bl;
    e.irq = il | (pl & ~str_m[0]) | (bl & ~str_m[1]);
    e.fiq = fl | (pl &  str_m[0]) | (bl &  str_m[1]);
    return e;
  endfunction

  // driver: called at a falling edge, leaves at the next falling edge
  task automatic step(input logic [3:0] pat, input string tag);
    ext_fiq_req = pat[0]; ext_irq_req = pat[1];
    pmu_req     = pat[2]; bus_req     = pat[3];
    rd_sel      = 2'd1;
    exp_q.push_back(model(pat[0], pat[1], pat[2], pat[3]));
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 2'd0) ctl_m = d[3:0];
    if (sel == 2'd2) str_m = d[1:0];
  endtask

  task automatic read_chk(input logic [1:0] sel, input logic [31:0] exp,
                          input string tag);
    rd_sel = sel;
    #1;
    chk(rd_data === exp, tag, rd_data, exp);
    @(negedge clk);
  endtask

  // monitor: one item per rising edge, sampled a quarter period later
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data === e.src, {t, " source"}, rd_data, e.src);
        chk({irq_o, fiq_o} === {e.irq, e.fiq}, {t, " irq/fiq"},
            {30'd0, irq_o, fiq_o}, {30'd0, e.irq, e.fiq});
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [3:0] cfg_ctl [6] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'h5, 4'hA};
    logic [1:0] cfg_str [6] = '{2'd0, 2'd3, 2'd1, 2'd2, 2'd1, 2'd2};
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    ext_fiq_req = 1'b1; ext_irq_req = 1'b1; pmu_req = 1'b1; bus_req = 1'b1;
    ctl_m = '0; str_m = '0;
    repeat (3) @(negedge clk);
    chk({irq_o, fiq_o} === 2'b00, "R1 outputs in reset", {30'd0, irq_o, fiq_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    read_chk(2'd0, 32'd0, "R1 control after reset");
    read_chk(2'd2, 32'd0, "R1 steer after reset");
    step(4'hF, "R1 R10 all masked");
    step(4'hF, "R1 R10 all masked");

    // R2 / R3 register widths
    write_reg(2'd0, 32'hFFFF_FFFF);
    read_chk(2'd0, 32'h0000_000F, "R2 control readback");
    write_reg(2'd0, 32'hA5A5_A5A6);
    read_chk(2'd0, 32'h0000_0006, "R2 control partial");
    write_reg(2'd2, 32'hFFFF_FFFF);
    read_chk(2'd2, 32'h0000_0003, "R3 steer readback");
    write_reg(2'd2, 32'h8000_0001);
    read_chk(2'd2, 32'h0000_0001, "R3 steer partial");

    // R9 ignored writes
    write_reg(2'd1, 32'hFFFF_FFFF);
    write_reg(2'd3, 32'hFFFF_FFFF);
    read_chk(2'd0, 32'h0000_0006, "R9 control kept");
    read_chk(2'd2, 32'h0000_0001, "R9 steer kept");
    read_chk(2'd3, 32'd0, "R9 select 3 reads zero");

    // R4 R5 R6 R7 R10: every request pattern under each configuration
    for (int c = 0; c < 6; c++) begin
      write_reg(2'd0, {28'hFFF_FFFF, cfg_ctl[c]});
      write_reg(2'd2, {30'h3FFF_FFFF, cfg_str[c]});
      for (int p = 0; p < 16; p++) begin
        step(p[3:0], "R4 R5 R6 R7 R10 pattern");
      end
    end
    @(negedge clk);
    @(negedge clk);

    // R8 one-edge latency
    write_reg(2'd0, 32'h0000_0004);
    write_reg(2'd2, 32'h0000_0000);
    ext_fiq_req = 1'b0; ext_irq_req = 1'b0; pmu_req = 1'b0; bus_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pmu_req = 1'b1;
    #1;
    chk(irq_o === 1'b0, "R8 irq_o before edge", {31'd0, irq_o}, 32'd0);
    @(posedge clk);
    #1;
    chk(irq_o === 1'b1, "R8 irq_o after edge", {31'd0, irq_o}, 32'd1);
    chk(fiq_o === 1'b0, "R8 fiq_o stays low", {31'd0, fiq_o}, 32'd0);
    @(negedge clk);
    pmu_req = 1'b0;
    @(posedge clk);
    #1;
    chk(irq_o === 1'b0, "R8 irq_o falls after edge", {31'd0, irq_o}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule